// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block serialises bytes onto an idle-high asynchronous line. A frame has a low start bit, the data bits least significant first, an optional extra bit, and one or two high stop bits. The extra bit depends on the selected format. In multiprocessor format it is a per-frame tag: 1 marks a receiver-address (ID) frame and 0 marks a payload frame. Otherwise it can be an even or odd parity bit, or it can be left out. Any parity setting has no effect while the multiprocessor format is selected.

The host has a one-entry holding register in front of the shift register. The host reads `emptyFlag` to learn that the holding register is free. Software writes a byte together with its tag, then strobes a clear of the flag to hand the byte over. A DMA engine instead uses a single write strobe that loads the byte and clears the flag in one step. Whenever the shift register is free and the holding register is full, the byte moves across and `emptyFlag` returns to 1. This lets a second frame follow with no idle gap. `txEnd` reports that the line has gone quiet. `txIrq` requests service while the holding register is free.

Each bit lasts 16 pulses of the `baudTick` enable input.

Top module: `mpUartTx`

## Requirements
- R1: After reset, `txd` is 1, `emptyFlag` is 1 and `txEnd` is 1.
- R2: A frame is a 0 start bit, then 8 data bits with bit 0 first, then the extra bit if present, then the stop bits at 1. Between frames the line stays 1.
- R3: Each bit of a frame is held for exactly 16 `baudTick` pulses. With `baudTick` held high, the start bit lasts 16 clock cycles.
- R4: With `cfgMpMode`=1, the extra bit is always present. Its value is the `wrMpb` value sampled with the byte, and `cfgParityEn` and `cfgParityOdd` have no effect.
- R5: With `cfgMpMode`=0 and `cfgParityEn`=1, the extra bit is the XOR of the data bits, inverted when `cfgParityOdd`=1. With `cfgParityEn`=0, the frame has no extra bit.
- R6: `cfgTwoStop`=1 sends two stop bits, and `cfgTwoStop`=0 sends one.
- R7: `wrData` and `dmaWr` take effect only while `emptyFlag`=1. While it is 0, they change neither the flag nor any frame.
- R8: `clrEmpty` drops `emptyFlag` to 0 only if a `wrData` was accepted since the flag last became 1. Otherwise it is ignored.
- R9: When `emptyFlag`=1, `dmaWr` loads the byte and tag and drops `emptyFlag` to 0 in the same cycle.
- R10: When the shift register is free, or finishes its last stop bit, and `emptyFlag`=0, the held byte is transferred and `emptyFlag` returns to 1. The next start bit follows the previous stop bit directly.
- R11: `txEnd` becomes 1 at the end of the last stop bit when no byte is waiting. It returns to 0 when a byte is transferred.
- R12: `txIrq` is 1 exactly when `emptyFlag`=1 and `txIrqEn`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | Baud enable, 16 pulses per bit |
| cfgMpMode | input | 1 | Selects the multiprocessor format |
| cfgParityEn | input | 1 | Adds a parity bit when not in multiprocessor format |
| cfgParityOdd | input | 1 | Selects odd parity |
| cfgTwoStop | input | 1 | Selects two stop bits |
| txIrqEn | input | 1 | Enables the empty interrupt request |
| wrData | input | 1 | Software write strobe for byte and tag |
| dmaWr | input | 1 | DMA write strobe that also clears the flag |
| clrEmpty | input | 1 | Software clear strobe for the empty flag |
| wrByte | input | 8 | Byte to send |
| wrMpb | input | 1 | Tag value (1 = ID frame) sent with the byte |
| txd | output | 1 | Serial line |
| emptyFlag | output | 1 | Holding register is free |
| txEnd | output | 1 | Line is idle with nothing pending |
| txIrq | output | 1 | Empty interrupt request |

## Verification
The assertions assume that the configuration inputs stay constant while a frame is on the line and that `baudTick` is a clean one-cycle-per-pulse enable. The stimulus changes the format only after `txEnd` has risen. The checks that `txd` changes only on a tick or a transfer rely on there being no other source of change. To exercise the ignore rules, the bench drives writes and clears both while the holding register is occupied and while it is not.

// File: rtl/mpTxPkg.sv
package mpTxPkg;
  typedef struct packed {
    logic holdWr;     // latch byte and tag into the holding register
    logic loadShift;  // move holding register into the shift register
    logic shiftBit;   // advance the line by one bit
  } txStrobeT;
endpackage

// File: rtl/mpTxCtrl.sv
module mpTxCtrl
  import mpTxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     baudTick,
  input  logic     wrData,
  input  logic     dmaWr,
  input  logic     clrEmpty,
  input  logic     cfgMpMode,
  input  logic     cfgParityEn,
  input  logic     cfgTwoStop,
  output txStrobeT strb,
  output logic     emptyFlag,
  output logic     txEnd,
  output logic     wrPending
);
  localparam int TICK_W  = $clog2(TICKS_PER_BIT);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_BIT - 1);

  logic [TICK_W-1:0] tickCnt;
  logic [CNT_W-1:0]  bitsLeft;
  logic [CNT_W-1:0]  frameLen;
  logic              busy;
  logic              bitEnd;
  logic              frameDone;
  logic              loadNow;
  logic              hostTake;

  assign bitEnd    = busy && baudTick && (tickCnt == LAST_TICK);
  assign frameDone = bitEnd && (bitsLeft == CNT_W'(1));
  assign loadNow   = (!busy || frameDone) && !emptyFlag;
  assign hostTake  = emptyFlag && (dmaWr || (clrEmpty && wrPending));
  assign frameLen  = CNT_W'(DATA_W + 2) + CNT_W'(cfgMpMode | cfgParityEn) + CNT_W'(cfgTwoStop);

  always_comb begin
    strb.holdWr    = emptyFlag && (wrData || dmaWr);
    strb.loadShift = loadNow;
    strb.shiftBit  = bitEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt   <= '0;
      bitsLeft  <= '0;
      busy      <= 1'b0;
      emptyFlag <= 1'b1;
      txEnd     <= 1'b1;
      wrPending <= 1'b0;
    end else begin
      if (loadNow) begin
        tickCnt  <= '0;
        bitsLeft <= frameLen;
        busy     <= 1'b1;
        txEnd    <= 1'b0;
      end else begin
        if (busy && baudTick) tickCnt <= (tickCnt == LAST_TICK) ? '0 : tickCnt + 1'b1;
        if (bitEnd) bitsLeft <= bitsLeft - 1'b1;
        if (frameDone) begin
          busy  <= 1'b0;
          txEnd <= 1'b1;
        end
      end
      if (loadNow) emptyFlag <= 1'b1;
      else if (hostTake) emptyFlag <= 1'b0;
      if (emptyFlag) begin
        if (hostTake) wrPending <= 1'b0;
        else if (wrData) wrPending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpTxDatapath.sv
module mpTxDatapath
  import mpTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          strb,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              wrMpb,
  input  logic              cfgMpMode,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  output logic              serBit
);
  localparam int FRAME_W = DATA_W + 4;

  logic [DATA_W-1:0]  holdData;
  logic               holdMpb;
  logic [FRAME_W-1:0] shiftReg;
  logic               extraBit;
  logic [FRAME_W-1:0] frameVec;

  always_comb begin
    extraBit = cfgMpMode ? holdMpb : ((^holdData) ^ cfgParityOdd);
    if (cfgMpMode || cfgParityEn) frameVec = {2'b11, extraBit, holdData, 1'b0};
    else                          frameVec = {3'b111, holdData, 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      holdMpb  <= 1'b0;
      shiftReg <= '1;
    end else begin
      if (strb.holdWr) begin
        holdData <= wrByte;
        holdMpb  <= wrMpb;
      end
      if (strb.loadShift)     shiftReg <= frameVec;
      else if (strb.shiftBit) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  assign serBit = shiftReg[0];
endmodule

// File: rtl/mpUartTx.sv
module mpUartTx
  import mpTxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              cfgMpMode,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic              txIrqEn,
  input  logic              wrData,
  input  logic              dmaWr,
  input  logic              clrEmpty,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              wrMpb,
  output logic              txd,
  output logic              emptyFlag,
  output logic              txEnd,
  output logic              txIrq
);
  txStrobeT strb;
  logic     wrPending;

  mpTxCtrl #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrData(wrData), .dmaWr(dmaWr),
    .clrEmpty(clrEmpty), .cfgMpMode(cfgMpMode), .cfgParityEn(cfgParityEn),
    .cfgTwoStop(cfgTwoStop), .strb(strb), .emptyFlag(emptyFlag), .txEnd(txEnd),
    .wrPending(wrPending)
  );

  mpTxDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(wrByte), .wrMpb(wrMpb),
    .cfgMpMode(cfgMpMode), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .serBit(txd)
  );

  assign txIrq = emptyFlag & txIrqEn;
endmodule

// File: rtl/mpUartTxChk.sv
module mpUartTxChk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic txd,
  input logic emptyFlag,
  input logic txEnd,
  input logic dmaWr,
  input logic wrPending
);
  // R8: without an accepted write, only a DMA write can drop the flag
  a_r8_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFlag && !wrPending && !dmaWr) |=> emptyFlag);

  // R11: leaving idle needs a byte waiting in the holding register
  a_r11_end_on_load: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnd) |-> $past(!emptyFlag));

  // R2: a frame leaving idle begins with a low start bit
  a_r2_start_after_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnd) |-> !txd);

  // R10: the refill of the empty flag comes with an active frame
  a_r10_refill_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyFlag) |-> !txEnd);

  // R3: the line moves only on a baud tick or on a transfer
  a_r3_txd_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txd) |-> ($past(baudTick) || $past(!emptyFlag)));
endmodule

bind mpUartTx mpUartTxChk u_chk (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .txd(txd), .emptyFlag(emptyFlag),
  .txEnd(txEnd), .dmaWr(dmaWr), .wrPending(wrPending)
);

// File: tb/mpUartTx_tb.sv
`timescale 1ns/1ps
module mpUartTx_tb;
  logic clk = 1'b0, rstN = 1'b0, baudTick = 1'b0;
  logic cfgMpMode = 1'b1, cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0;
  logic txIrqEn = 1'b1, wrData = 1'b0, dmaWr = 1'b0, clrEmpty = 1'b0, wrMpb = 1'b0;
  logic [7:0] wrByte = 8'h00;
  logic txd, emptyFlag, txEnd, txIrq;

  int checks = 0, errors = 0, cycles = 0, tickPeriod = 3, tickDiv = 0;
  string reqTag = "R1";

  // reference model state
  bit mEmpty = 1, mWritten = 0, mEnd = 1, mBusy = 0, mMpb = 0;
  byte unsigned mData = 0;
  int mTick = 0;
  bit mBits[$];

  always #2.5 clk = ~clk;

  mpUartTx u_dut (.*);

  always @(negedge clk) begin
    tickDiv++;
    baudTick = (tickPeriod <= 1) || ((tickDiv % tickPeriod) == 0);
  end

  always @(posedge clk) begin
    bit preEmpty, preWritten, preBusy, done;
    if (!rstN) begin
      mEmpty = 1; mWritten = 0; mEnd = 1; mBusy = 0; mTick = 0; mData = 0; mMpb = 0;
      mBits.delete();
    end else begin
      preEmpty = mEmpty; preWritten = mWritten; preBusy = mBusy; done = 0;
      if (mBusy && baudTick) begin
        if (mTick == 15) begin
          mTick = 0;
          void'(mBits.pop_front());
          if (mBits.size() == 0) done = 1;
        end else mTick++;
      end
      if ((!preBusy || done) && !preEmpty) begin
        mBits.delete();
        mBits.push_back(1'b0);
        for (int i = 0; i < 8; i++) mBits.push_back(mData[i]);
        if (cfgMpMode) mBits.push_back(mMpb);
        else if (cfgParityEn) mBits.push_back((^mData) ^ cfgParityOdd);
        mBits.push_back(1'b1);
        if (cfgTwoStop) mBits.push_back(1'b1);
        mTick = 0; mBusy = 1; mEmpty = 1; mEnd = 0;
      end else if (done) begin
        mBusy = 0; mEnd = 1;
      end
      if (preEmpty) begin
        if (dmaWr) begin
          mData = wrByte; mMpb = wrMpb; mEmpty = 0; mWritten = 0;
        end else begin
          if (wrData) begin mData = wrByte; mMpb = wrMpb; end
          if (clrEmpty && preWritten) begin mEmpty = 0; mWritten = 0; end
          else if (wrData) mWritten = 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk); #1;
    if (rstN) begin
      bit expTxd;
      expTxd = mBusy ? mBits[0] : 1'b1;
      check(txd == expTxd, reqTag, "txd", txd, expTxd);
      check(emptyFlag == mEmpty, "R10", "emptyFlag", emptyFlag, mEmpty);
      check(txEnd == mEnd, "R11", "txEnd", txEnd, mEnd);
      check(txIrq == (mEmpty & txIrqEn), "R12", "txIrq", txIrq, mEmpty & txIrqEn);
    end
  end

  task automatic pulseWrite(input logic [7:0] b, input logic m);
    @(negedge clk); wrData = 1; wrByte = b; wrMpb = m;
    @(negedge clk); wrData = 0;
  endtask
  task automatic pulseClear();
    @(negedge clk); clrEmpty = 1;
    @(negedge clk); clrEmpty = 0;
  endtask
  task automatic pulseDma(input logic [7:0] b, input logic m);
    @(negedge clk); dmaWr = 1; wrByte = b; wrMpb = m;
    @(negedge clk); dmaWr = 0;
  endtask
  task automatic waitEmpty();
    do @(negedge clk); while (!emptyFlag);
  endtask
  task automatic waitIdle();
    do @(negedge clk); while (!(txEnd && emptyFlag));
    repeat (3) @(negedge clk);
  endtask
  task automatic sendSw(input logic [7:0] b, input logic m);
    pulseWrite(b, m); pulseClear(); waitIdle();
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    check(txd == 1, "R1", "reset txd", txd, 1);
    check(emptyFlag == 1, "R1", "reset emptyFlag", emptyFlag, 1);
    check(txEnd == 1, "R1", "reset txEnd", txEnd, 1);

    // R8: a clear with no prior write is ignored
    reqTag = "R8";
    pulseClear(); #1;
    check(emptyFlag == 1, "R8", "clear without write", emptyFlag, 1);

    // R4: ID frame then data frame, parity settings must not matter
    reqTag = "R4";
    cfgMpMode = 1; cfgParityEn = 1; cfgParityOdd = 1;
    pulseWrite(8'h01, 1'b1); #1;
    check(emptyFlag == 1, "R8", "write alone keeps flag", emptyFlag, 1);
    pulseClear();
    waitEmpty(); #1;
    check(txEnd == 0, "R11", "txEnd low during frame", txEnd, 0);
    pulseWrite(8'hAA, 1'b0); pulseClear(); #1;
    check(emptyFlag == 0, "R10", "second byte queued", emptyFlag, 0);
    // R7: writes while full are ignored
    reqTag = "R7";
    pulseWrite(8'h55, 1'b1); pulseDma(8'h66, 1'b1); pulseClear(); #1;
    check(emptyFlag == 0, "R7", "write while full ignored", emptyFlag, 0);
    waitIdle();
    check(txd == 1, "R2", "line idle high", txd, 1);

    // R9: DMA write loads and clears in one step
    reqTag = "R9";
    @(negedge clk); dmaWr = 1; wrByte = 8'h3C; wrMpb = 1;
    @(negedge clk); dmaWr = 0; #1;
    check(emptyFlag == 0 || txEnd == 0, "R9", "dma cleared flag", emptyFlag, 0);
    waitIdle();

    // R5: parity formats
    reqTag = "R5";
    cfgMpMode = 0; cfgParityEn = 1; cfgParityOdd = 0; sendSw(8'hA7, 1'b1);
    cfgParityOdd = 1; sendSw(8'hA7, 1'b0);
    cfgParityEn = 0; sendSw(8'h5A, 1'b1);

    // R6: two stop bits, back-to-back
    reqTag = "R6";
    cfgTwoStop = 1; cfgMpMode = 1;
    pulseWrite(8'h81, 1'b1); pulseClear(); waitEmpty();
    pulseWrite(8'h7E, 1'b0); pulseClear(); waitIdle();
    cfgTwoStop = 0;

    // R12: interrupt mask
    reqTag = "R12";
    @(negedge clk); txIrqEn = 0; #1;
    check(txIrq == 0, "R12", "masked irq", txIrq, 0);
    @(negedge clk); txIrqEn = 1; #1;
    check(txIrq == 1, "R12", "unmasked irq", txIrq, 1);

    // R3: with a permanent tick, the start bit lasts 16 cycles
    reqTag = "R3";
    tickPeriod = 1;
    pulseWrite(8'hFF, 1'b1); pulseClear();
    begin
      int lowCnt = 0;
      while (txd == 1) @(negedge clk);
      while (txd == 0) begin lowCnt++; @(negedge clk); end
      check(lowCnt == 16, "R3", "start bit length", lowCnt, 16);
    end
    waitIdle();
    tickPeriod = 3;

    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule